// File: doc/BRIEF.md
# Pseudo-Random Sequence Receive Checker

This block watches a recovered serial bit stream, one bit per receive clock, and checks it against a pseudo-random sequence. Software selects the sequence with a rate input. A long sequence of period 2^23-1 serves the higher line rate, and a short sequence of period 2^15-1 serves the lower rates. The checker needs no seed from the transmitter. It copies received bits into a local shift register until that register predicts the stream by itself. It then declares lock, and from then on it runs its predictor freely, so that a single corrupted bit shows up as exactly one error.

Three outputs report the result. The first is a combined status line: high while lock is missing, low while locked, and high for the low half of the receive clock in every cycle that carries a bit error. The second is a sync-loss flag. The third is a one-cycle error strobe, meant for an external error counter. Lock is dropped when too many errors fall inside a sliding window of recent bits. Acquisition then starts again from the incoming data.

The controller is a four-state machine:
- IDLE: the checker is disabled.
- SEED: the predictor is filled with received bits and nothing is compared.
- HUNT: received bits are compared and a run of matches is counted.
- LOCK: the predictor runs freely and errors are tracked in the window.

Its transitions are:
- enable: IDLE to SEED.
- fill done: SEED to HUNT.
- run complete: HUNT to LOCK.
- window overflow: LOCK to SEED.
- rate change: any active state to SEED.
- disable: any state to IDLE.

Top module: `prbs_rx_checker`

## Requirements
- R1: While `rst_n` is low, and at every clock edge that samples `chk_en` low, the state returns to IDLE. In IDLE, `sync_lost`, `err_strobe` and `stat_line` are all 0. An edge that samples `chk_en` high in IDLE moves to SEED, and the bit sampled at that edge is not used.
- R2: With `rate_sel`=1 the expected stream obeys b[n] = b[n-23] XOR b[n-18]. With `rate_sel`=0 it obeys b[n] = b[n-15] XOR b[n-14]. Here b[n] is the bit sampled at the n-th rising edge of `clk_rx`.
- R3: SEED consumes 23 bits (long rate) or 15 bits (short rate) with no comparison. HUNT then counts consecutive matches and moves to LOCK on the edge that samples the 32nd consecutive matching bit. After 31 matches `sync_lost` is still 1; after the 32nd it is 0.
- R4: While enabled and not in LOCK (SEED or HUNT), `sync_lost` is 1 and `stat_line` is 1 in both clock phases.
- R5: In HUNT every mismatching bit raises `err_strobe` for the one clock cycle after the edge that sampled it. In SEED, `err_strobe` stays 0 whatever data arrives.
- R6: In LOCK the predictor shifts in its own predicted bit. A single flipped bit therefore raises `err_strobe` for exactly one cycle, the cycle after its sampling edge, and the next correct bit raises none.
- R7: In LOCK, `stat_line` is 0 during the high phase of `clk_rx`. During the low phase it equals `err_strobe`.
- R8: In LOCK, an error flag is kept for each of the last 64 sampled bits, the current one included. On the edge where that count reaches 8, the state goes to SEED and `sync_lost` becomes 1. That edge's error still raises `err_strobe`. The checker then reacquires from the received data.
- R9: An edge that samples `rate_sel` different from the rate in use, while the checker is enabled and not in IDLE, moves to SEED with `err_strobe` 0. Acquisition restarts at the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive bit clock; data sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Checker enable |
| rate_sel | input | 1 | 1 selects the 2^23-1 sequence, 0 the 2^15-1 sequence |
| rx_bit | input | 1 | Received serial data bit |
| stat_line | output | 1 | Combined status: high when unlocked, half-period high pulse per error when locked |
| sync_lost | output | 1 | 1 while enabled and not locked |
| err_strobe | output | 1 | One-cycle pulse per detected bit error |

## Verification
The bench builds the block with its default parameters:
- 23/18 and 15/14 taps;
- a lock run of 32;
- a 64-bit loss window with a threshold of 8.

With these values both sequence rates can be reached in a few hundred cycles. A short vector walk places seven errors in the window and shows that lock holds. It also shows that the eighth error drops lock when it lands on the 64th bit of the window, but not once the oldest error has slid out. Both lock boundaries (31 versus 32 matches) are probed at each rate. A corrupted bit during HUNT is followed through its later echoes at the tap positions before lock returns.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_HUNT = 2'd2,
        ST_LOCK = 2'd3
    } chk_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prbs_pred.sv
// Local sequence predictor: a shift register that either copies the
// received stream (self-synchronising) or runs on its own prediction.
module prbs_pred #(
    parameter int LONG_ORD  = 23,
    parameter int LONG_TAP  = 18,
    parameter int SHORT_ORD = 15,
    parameter int SHORT_TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic use_long,
    input  logic take_rx,
    input  logic rx_bit,
    output logic pred_bit
);
    import prbs_chk_pkg::*;

    localparam int REG_W = max_of(LONG_ORD, SHORT_ORD);

    logic [REG_W-1:0] sr_q;
    logic             long_fb;
    logic             short_fb;
    logic             in_bit;

    // r[k] holds the bit sampled k+1 edges ago
    generate
        if (REG_W == LONG_ORD) begin : g_long_full
            assign long_fb = sr_q[LONG_ORD-1] ^ sr_q[LONG_TAP-1];
        end else begin : g_long_part
            assign long_fb = sr_q[LONG_ORD-1] ^ sr_q[LONG_TAP-1];
        end
    endgenerate

    assign short_fb = sr_q[SHORT_ORD-1] ^ sr_q[SHORT_TAP-1];
    assign pred_bit = use_long ? long_fb : short_fb;
    assign in_bit   = take_rx ? rx_bit : pred_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[REG_W-2:0], in_bit};
        end
    end

endmodule

// File: rtl/prbs_err_window.sv
// Sliding count of error flags over the last WIN_LEN sampled bits.
module prbs_err_window #(
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic valid,
    input  logic err_in,
    output logic overflow
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_ERRS);

    logic [WIN_LEN-1:0] hist_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_next;

    assign cnt_next = cnt_q + CNT_W'(err_in) - CNT_W'(hist_q[WIN_LEN-1]);
    assign overflow = valid && (cnt_next >= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (valid) begin
            hist_q <= {hist_q[WIN_LEN-2:0], err_in};
            cnt_q  <= cnt_next;
        end
    end

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
    parameter int LONG_ORD  = 23,
    parameter int LONG_TAP  = 18,
    parameter int SHORT_ORD = 15,
    parameter int SHORT_TAP = 14,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk_rx,
    input  logic rst_n,
    input  logic chk_en,
    input  logic rate_sel,
    input  logic rx_bit,
    output logic stat_line,
    output logic sync_lost,
    output logic err_strobe
);
    import prbs_chk_pkg::*;

    localparam int FILL_W = $clog2(max_of(LONG_ORD, SHORT_ORD) + 1);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam logic [FILL_W-1:0] FILL_LONG_END  = FILL_W'(LONG_ORD - 1);
    localparam logic [FILL_W-1:0] FILL_SHORT_END = FILL_W'(SHORT_ORD - 1);
    localparam logic [RUN_W-1:0]  RUN_END        = RUN_W'(LOCK_RUN - 1);

    chk_state_e        state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic              rate_q, rate_d;
    logic              err_q, err_d;

    logic pred_bit;
    logic mismatch;
    logic win_over;
    logic fill_end;
    logic rate_chg;

    prbs_pred #(
        .LONG_ORD (LONG_ORD),
        .LONG_TAP (LONG_TAP),
        .SHORT_ORD(SHORT_ORD),
        .SHORT_TAP(SHORT_TAP)
    ) u_pred (
        .clk     (clk_rx),
        .rst_n   (rst_n),
        .shift_en(state_q != ST_IDLE),
        .use_long(rate_q),
        .take_rx (state_q != ST_LOCK),
        .rx_bit  (rx_bit),
        .pred_bit(pred_bit)
    );

    prbs_err_window #(
        .WIN_LEN  (WIN_LEN),
        .LOSS_ERRS(LOSS_ERRS)
    ) u_win (
        .clk     (clk_rx),
        .rst_n   (rst_n),
        .clear   (state_q != ST_LOCK),
        .valid   (state_q == ST_LOCK && chk_en && !rate_chg),
        .err_in  (mismatch),
        .overflow(win_over)
    );

    assign mismatch = rx_bit ^ pred_bit;
    assign fill_end = (fill_q == (rate_q ? FILL_LONG_END : FILL_SHORT_END));
    assign rate_chg = (rate_sel != rate_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        run_d   = run_q;
        rate_d  = rate_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_SEED;
                fill_d  = '0;
                rate_d  = rate_sel;
            end
            ST_SEED: begin
                fill_d = fill_q + 1'b1;
                if (fill_end) begin
                    state_d = ST_HUNT;
                    run_d   = '0;
                end
            end
            ST_HUNT: begin
                err_d = mismatch;
                if (mismatch) begin
                    run_d = '0;
                end else if (run_q == RUN_END) begin
                    state_d = ST_LOCK;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            ST_LOCK: begin
                err_d = mismatch;
                if (win_over) begin
                    state_d = ST_SEED;
                    fill_d  = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!chk_en) begin
            state_d = ST_IDLE;
            err_d   = 1'b0;
        end else if (state_q != ST_IDLE && rate_chg) begin
            state_d = ST_SEED;
            fill_d  = '0;
            rate_d  = rate_sel;
            err_d   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk_rx or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
            run_q   <= '0;
            rate_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            run_q   <= run_d;
            rate_q  <= rate_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        sync_lost  = (state_q == ST_SEED) || (state_q == ST_HUNT);
        err_strobe = err_q;
        stat_line  = sync_lost || (err_q && !clk_rx);
    end

endmodule

module prbs_rx_checker_sva (
    input logic                     clk_rx,
    input logic                     rst_n,
    input logic                     chk_en,
    input logic                     rate_sel,
    input logic                     stat_line,
    input logic                     sync_lost,
    input logic                     err_strobe,
    input logic                     win_over,
    input prbs_chk_pkg::chk_state_e state_q
);
    import prbs_chk_pkg::*;

    logic past_ok;
    always_ff @(posedge clk_rx or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_disable_quiet: assert property (@(posedge clk_rx) disable iff (!rst_n)
        !chk_en |=> (!sync_lost && !err_strobe && !stat_line));

    a_r4_lost_holds_status: assert property (@(posedge clk_rx) disable iff (!rst_n)
        sync_lost |-> stat_line);

    a_r3_lock_on_match: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (past_ok && chk_en && $past(chk_en) && $fell(sync_lost)) |-> !err_strobe);

    a_r5_seed_silent: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (chk_en && state_q == ST_SEED) |=> !err_strobe);

    a_r8_window_drops_lock: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (chk_en && state_q == ST_LOCK && win_over) |=> sync_lost);

    a_r9_rate_restart: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (past_ok && chk_en && !$stable(rate_sel)) |=> sync_lost);

endmodule

bind prbs_rx_checker prbs_rx_checker_sva u_sva (
    .clk_rx    (clk_rx),
    .rst_n     (rst_n),
    .chk_en    (chk_en),
    .rate_sel  (rate_sel),
    .stat_line (stat_line),
    .sync_lost (sync_lost),
    .err_strobe(err_strobe),
    .win_over  (win_over),
    .state_q   (state_q)
);

// File: tb/sim_prbs_rx_checker.sv
module sim_prbs_rx_checker;

    logic clk_rx = 1'b0;
    logic rst_n = 1'b0;
    logic chk_en = 1'b0;
    logic rate_sel = 1'b1;
    logic rx_bit = 1'b0;
    logic stat_line, sync_lost, err_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [22:0] gen = 23'h5A3C96;
    logic s_err, s_lost, s_hi, s_lo;

    always #10 clk_rx = ~clk_rx;

    prbs_rx_checker u0 (
        .clk_rx    (clk_rx),
        .rst_n     (rst_n),
        .chk_en    (chk_en),
        .rate_sel  (rate_sel),
        .rx_bit    (rx_bit),
        .stat_line (stat_line),
        .sync_lost (sync_lost),
        .err_strobe(err_strobe)
    );

    // {count[5:0], flip, exp_err, exp_lost}, walked after long-rate lock
    localparam int NVEC = 7;
    localparam logic [8:0] VEC [NVEC] = '{
        {6'd4,  1'b0, 1'b0, 1'b0},
        {6'd1,  1'b1, 1'b1, 1'b0},
        {6'd1,  1'b0, 1'b0, 1'b0},
        {6'd6,  1'b1, 1'b1, 1'b0},
        {6'd56, 1'b0, 1'b0, 1'b0},
        {6'd1,  1'b1, 1'b1, 1'b0},
        {6'd1,  1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        logic b;
        b = rate_sel ? (gen[22] ^ gen[17]) : (gen[14] ^ gen[13]);
        gen = {gen[21:0], b};
        return b;
    endfunction

    // drives one bit, samples in the high phase (+5) and low phase (+15)
    task automatic send(input logic flip);
        rx_bit = next_bit() ^ flip;
        @(posedge clk_rx);
        #5;
        s_err  = err_strobe;
        s_lost = sync_lost;
        s_hi   = stat_line;
        #10;
        s_lo   = stat_line;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_rx);
        #15;
        check("R1 reset lost", sync_lost, 1'b0);
        check("R1 reset err", err_strobe, 1'b0);
        check("R1 reset stat", stat_line, 1'b0);
        rst_n = 1'b1;

        // disabled: corrupted data does nothing
        for (int i = 0; i < 5; i++) begin
            send(1'b1);
            check("R1 idle err", s_err, 1'b0);
            check("R1 idle stat", s_lo, 1'b0);
            check("R1 idle lost", s_lost, 1'b0);
        end

        // long rate acquisition
        rate_sel = 1'b1;
        chk_en   = 1'b1;
        send(1'b0);
        check("R4 enter seed lost", s_lost, 1'b1);
        check("R4 stat high phase", s_hi, 1'b1);
        check("R4 stat low phase", s_lo, 1'b1);
        for (int i = 0; i < 23; i++) begin
            send(1'b0);
            check("R5 seed no err", s_err, 1'b0);
        end
        for (int i = 0; i < 31; i++) send(1'b0);
        check("R3 long 31 matches not locked", s_lost, 1'b1);
        send(1'b0);
        check("R3 R2 long 32 matches locked", s_lost, 1'b0);
        check("R7 locked stat hi", s_hi, 1'b0);
        check("R7 locked stat lo", s_lo, 1'b0);

        // table walk: single errors, window boundary
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < int'(VEC[v][8:3]); k++) begin
                send(VEC[v][2]);
                check("R6 err strobe", s_err, VEC[v][1]);
                check("R8 sync lost", s_lost, VEC[v][0]);
                check("R7 stat high phase", s_hi, VEC[v][0]);
                check("R7 stat low phase", s_lo, VEC[v][0] | VEC[v][1]);
            end
        end

        // reacquire after loss; error during hunt and its tap echoes
        for (int i = 0; i < 23; i++) begin
            send(1'b0);
            check("R5 reseed no err", s_err, 1'b0);
        end
        for (int i = 0; i < 4; i++) send(1'b0);
        send(1'b1);
        check("R5 hunt error strobe", s_err, 1'b1);
        check("R4 hunt still lost", s_lost, 1'b1);
        for (int i = 0; i < 54; i++) send(1'b0);
        check("R8 reacquire not yet", s_lost, 1'b1);
        send(1'b0);
        check("R8 reacquired", s_lost, 1'b0);

        // rate change restarts; short rate
        rate_sel = 1'b0;
        gen = 23'h001ACE;
        send(1'b0);
        check("R9 rate change lost", s_lost, 1'b1);
        check("R9 rate change err", s_err, 1'b0);
        for (int i = 0; i < 15; i++) send(1'b0);
        for (int i = 0; i < 31; i++) send(1'b0);
        check("R3 short 31 matches not locked", s_lost, 1'b1);
        send(1'b0);
        check("R2 short 32 matches locked", s_lost, 1'b0);
        send(1'b1);
        check("R6 short single err", s_err, 1'b1);
        send(1'b0);
        check("R6 short next clean", s_err, 1'b0);
        check("R6 short still locked", s_lost, 1'b0);

        // disable
        chk_en = 1'b0;
        send(1'b1);
        check("R1 disable lost", s_lost, 1'b0);
        check("R1 disable err", s_err, 1'b0);
        check("R1 disable stat", s_lo, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule